// File: doc/BRIEF.md
# Overload Restart and Fault Qualification Sequencer

This block decides, for each of several amplifier output channels, when the channel may drive and when it must be held off after an overload. Each channel sees an overload flag from its short-circuit protection and three fault comparators: output shorted to ground, output shorted to supply, and load shorted across. A free-running pulse, one clock wide and once per millisecond, sets the time base. Every channel runs its own state machine. An overload on one channel never affects another.

With diagnostics off, an overloaded channel is disabled and rechecked on a millisecond grid until the overload is gone. With diagnostics on, the first check after the overload acts as a spike filter. If the overload has vanished by then, the channel simply resumes. If it persists, a long qualification window runs with the channel held off. At the end of the window, each fault flag is latched only if its comparator stayed asserted for the whole window. The channel then falls back to restart behaviour. A completed cycle keeps its results, and further overloads get plain restart handling until the host reads the status and pulses the re-arm strobe. All pins are plain control and status levels. No data stream crosses the boundary, so there is no valid/ready handshake.

Top module: `ovl_seq_top`

## Requirements
- R1: After reset, every channel is enabled (ch_en = 1), and all fault flags, mode bits and cycle_done bits are 0.
- R2: With diag_en = 0, an overload seen at a clock edge with the channel enabled drives ch_en low from the next cycle. The overload is then re-sampled at every RESTART_MS-th ms_tick, counting only ticks after the disable edge. ch_en returns to 1 the cycle after a re-sample finds the overload gone.
- R3: Channels are independent: an overload or fault on one channel leaves the other channels' ch_en and status outputs unchanged.
- R4: With diag_en = 1 and cycle_done = 0, an overload disables the channel, and the overload is re-checked at the FILTER_MS-th following ms_tick. If it is absent there, the channel is re-enabled and cycle_done and the fault flags are unchanged.
- R5: If the overload is present at the filter check, a window of WINDOW_MS further ticks runs with ch_en = 0. When the window closes, the fault flags are loaded, cycle_done rises and the channel enters restart behaviour as in R2.
- R6: A fault flag is loaded as 1 only if its comparator was 1 at every clock edge of the window. Several comparators that meet this condition are all latched together.
- R7: While cycle_done = 1, an overload gets restart handling only and no new window starts. A rearm pulse clears cycle_done on the following edge, unless a window closes on that same edge.
- R8: flt_perm becomes 1 when a window closes. Latched fault flags change only when a window closes, and a rearm pulse does not clear them.
- R9: If diag_en falls during the filter or the window, the cycle is abandoned. cycle_done is cleared and the channel continues in restart behaviour without loading flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| diag_en | input | 1 | Diagnostic cycles allowed (all channels) |
| rearm | input | 1 | Status-read strobe, re-arms the diagnostic cycle |
| ovl | input | NCH | Per-channel overload flag |
| cmp_gnd | input | NCH | Per-channel short-to-ground comparator |
| cmp_sup | input | NCH | Per-channel short-to-supply comparator |
| cmp_load | input | NCH | Per-channel shorted-load comparator |
| ch_en | output | NCH | Channel output stage enable |
| flt_gnd | output | NCH | Latched short-to-ground flag |
| flt_sup | output | NCH | Latched short-to-supply flag |
| flt_load | output | NCH | Latched shorted-load flag |
| flt_perm | output | NCH | Result mode: 0 turn-on, 1 permanent |
| cycle_done | output | NCH | Diagnostic cycle finished, waiting for rearm |

## Verification
A wrong state or timer count shows up at ch_en first. A channel that resumes one tick early or late, or that stays off during a spike, differs on that clock, within at most one tick period of the fault. A wrong comparator accumulation stays hidden until the window closes, and then appears in the flag outputs on exactly that edge. A wrong cycle_done sequence appears at the next overload, because the channel then either opens a window when it should restart, or restarts when it should open a window. The reference model is compared with every output on every clock, so each of these is caught on the first divergent cycle.

// File: rtl/ovl_seq_pkg.sv
package ovl_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_RESTART = 2'd1,
    ST_FILTER  = 2'd2,
    ST_WINDOW  = 2'd3
  } ch_state_e;

  typedef struct packed {
    logic to_gnd;
    logic to_sup;
    logic load_short;
  } fault_t;
endpackage

// File: rtl/ovl_tick_timer.sv
module ovl_tick_timer #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  assign expire = tick && !clear && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (expire)   cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ovl_fault_accum.sv
module ovl_fault_accum
  import ovl_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_window,
  input  logic   commit,
  input  fault_t cmp,
  output fault_t latched
);
  fault_t acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_q <= '1;
    else if (!in_window) acc_q <= '1;
    else                 acc_q <= acc_q & cmp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      latched <= '0;
    else if (commit) latched <= acc_q & cmp;
  end
endmodule

// File: rtl/ovl_channel.sv
module ovl_channel
  import ovl_seq_pkg::*;
#(
  parameter int FILTER_MS  = 1,
  parameter int WINDOW_MS  = 100,
  parameter int RESTART_MS = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ms_tick,
  input  logic   diag_en,
  input  logic   rearm,
  input  logic   ovl,
  input  fault_t cmp,
  output logic   ch_en,
  output fault_t flags,
  output logic   perm,
  output logic   done
);
  localparam int MAXL = (WINDOW_MS > FILTER_MS) ?
                        ((WINDOW_MS > RESTART_MS) ? WINDOW_MS : RESTART_MS) :
                        ((FILTER_MS > RESTART_MS) ? FILTER_MS : RESTART_MS);
  localparam int CW = $clog2(MAXL + 1);

  ch_state_e     state_q, state_d;
  logic [CW-1:0] limit;
  logic          expire, abort, tmr_clr, closing;

  assign abort   = !diag_en && (state_q == ST_FILTER || state_q == ST_WINDOW);
  assign tmr_clr = (state_q == ST_RUN) || abort;
  assign closing = (state_q == ST_WINDOW) && expire;
  assign ch_en   = (state_q == ST_RUN);

  always_comb begin
    case (state_q)
      ST_FILTER: limit = CW'(FILTER_MS);
      ST_WINDOW: limit = CW'(WINDOW_MS);
      default:   limit = CW'(RESTART_MS);
    endcase
  end

  ovl_tick_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clr), .tick(ms_tick),
    .limit(limit), .expire(expire)
  );

  ovl_fault_accum u_accum (
    .clk(clk), .rst_n(rst_n), .in_window(state_q == ST_WINDOW),
    .commit(closing), .cmp(cmp), .latched(flags)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:     if (ovl) state_d = (diag_en && !done) ? ST_FILTER : ST_RESTART;
      ST_RESTART: if (expire && !ovl) state_d = ST_RUN;
      ST_FILTER:  if (abort) state_d = ST_RESTART;
                  else if (expire) state_d = ovl ? ST_WINDOW : ST_RUN;
      ST_WINDOW:  if (abort || expire) state_d = ST_RESTART;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      done    <= 1'b0;
      perm    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (closing)              done <= 1'b1;
      else if (rearm || abort)  done <= 1'b0;
      if (closing)              perm <= 1'b1;
    end
  end

  assert_off_after_ovl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && ovl) |=> !ch_en);
  assert_done_implies_perm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> perm);
  assert_flags_move_on_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flags) |-> $rose(done));
  assert_rearm_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm && state_q != ST_WINDOW) |=> !done);
  assert_abort_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!done && state_q == ST_RESTART && $stable(flags)));
  assert_no_window_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && state_q == ST_RUN) |=> (state_q != ST_FILTER));
endmodule

// File: rtl/ovl_seq_top.sv
module ovl_seq_top
  import ovl_seq_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int FILTER_MS  = 1,
  parameter int WINDOW_MS  = 100,
  parameter int RESTART_MS = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ms_tick,
  input  logic           diag_en,
  input  logic           rearm,
  input  logic [NCH-1:0] ovl,
  input  logic [NCH-1:0] cmp_gnd,
  input  logic [NCH-1:0] cmp_sup,
  input  logic [NCH-1:0] cmp_load,
  output logic [NCH-1:0] ch_en,
  output logic [NCH-1:0] flt_gnd,
  output logic [NCH-1:0] flt_sup,
  output logic [NCH-1:0] flt_load,
  output logic [NCH-1:0] flt_perm,
  output logic [NCH-1:0] cycle_done
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    fault_t cmp_c, flg_c;
    assign cmp_c = '{to_gnd: cmp_gnd[c], to_sup: cmp_sup[c], load_short: cmp_load[c]};
    ovl_channel #(
      .FILTER_MS(FILTER_MS), .WINDOW_MS(WINDOW_MS), .RESTART_MS(RESTART_MS)
    ) u_ch (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .diag_en(diag_en),
      .rearm(rearm), .ovl(ovl[c]), .cmp(cmp_c), .ch_en(ch_en[c]),
      .flags(flg_c), .perm(flt_perm[c]), .done(cycle_done[c])
    );
    assign flt_gnd[c]  = flg_c.to_gnd;
    assign flt_sup[c]  = flg_c.to_sup;
    assign flt_load[c] = flg_c.load_short;
  end
endmodule

// File: tb/ovl_seq_top_tb.sv
module ovl_seq_top_tb_top;
  localparam int NCH = 4, FILT = 1, WIN = 100, RST = 1, TDIV = 8;

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0, diag_en = 1'b0, rearm = 1'b0;
  logic [NCH-1:0] ovl = '0, cmp_gnd = '0, cmp_sup = '0, cmp_load = '0;
  logic [NCH-1:0] ch_en, flt_gnd, flt_sup, flt_load, flt_perm, cycle_done;

  always #2.5 clk = ~clk;

  ovl_seq_top #(.NCH(NCH), .FILTER_MS(FILT), .WINDOW_MS(WIN), .RESTART_MS(RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .diag_en(diag_en), .rearm(rearm),
    .ovl(ovl), .cmp_gnd(cmp_gnd), .cmp_sup(cmp_sup), .cmp_load(cmp_load),
    .ch_en(ch_en), .flt_gnd(flt_gnd), .flt_sup(flt_sup), .flt_load(flt_load),
    .flt_perm(flt_perm), .cycle_done(cycle_done)
  );

  int vectors = 0, errors = 0, cyc = 0, tcnt = 0;
  // reference model: mode 0 running, 1 restart, 2 spike check, 3 window
  int m_mode[NCH], m_cnt[NCH], m_done[NCH], m_perm[NCH];
  int m_f[NCH][3], m_st[NCH][3];

  task automatic chk(input int act, input int exp, input string req);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // tick generator, driven away from the active edge
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % TDIV;
    ms_tick <= (tcnt == 0);
  end

  always @(posedge clk) begin
    cyc++;
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        m_mode[c] = 0; m_cnt[c] = 0; m_done[c] = 0; m_perm[c] = 0;
        for (int k = 0; k < 3; k++) begin m_f[c][k] = 0; m_st[c][k] = 1; end
      end else begin
        int lim, ab, ex, cur[3], nm;
        cur[0] = cmp_gnd[c]; cur[1] = cmp_sup[c]; cur[2] = cmp_load[c];
        lim = (m_mode[c] == 2) ? FILT : (m_mode[c] == 3) ? WIN : RST;
        ab  = (!diag_en && m_mode[c] >= 2) ? 1 : 0;
        ex  = (ms_tick && !ab && m_mode[c] != 0 && m_cnt[c] == lim - 1) ? 1 : 0;
        nm  = m_mode[c];
        if (m_mode[c] == 0 && ovl[c]) nm = (diag_en && !m_done[c]) ? 2 : 1;
        else if (m_mode[c] == 1 && ex && !ovl[c]) nm = 0;
        else if (m_mode[c] == 2) nm = ab ? 1 : (ex ? (ovl[c] ? 3 : 0) : 2);
        else if (m_mode[c] == 3 && (ab || ex)) nm = 1;
        if (m_mode[c] == 3 && ex) begin
          for (int k = 0; k < 3; k++) m_f[c][k] = m_st[c][k] & cur[k];
          m_done[c] = 1; m_perm[c] = 1;
        end else if (rearm || ab) m_done[c] = 0;
        for (int k = 0; k < 3; k++) m_st[c][k] = (m_mode[c] == 3) ? (m_st[c][k] & cur[k]) : 1;
        if (m_mode[c] == 0 || ab || ex) m_cnt[c] = 0;
        else if (ms_tick) m_cnt[c]++;
        m_mode[c] = nm;
      end
    end
  end

  // full compare every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    for (int c = 0; c < NCH; c++) begin
      chk(ch_en[c], m_mode[c] == 0, "R2/R4 ch_en");
      chk(flt_gnd[c], m_f[c][0], "R6 flt_gnd");
      chk(flt_sup[c], m_f[c][1], "R6 flt_sup");
      chk(flt_load[c], m_f[c][2], "R6 flt_load");
      chk(flt_perm[c], m_perm[c], "R8 flt_perm");
      chk(cycle_done[c], m_done[c], "R7 cycle_done");
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    // R1: reset values
    chk(ch_en, 4'hF, "R1 ch_en"); chk(cycle_done, 0, "R1 done"); chk(flt_perm, 0, "R1 perm");
    rst_n = 1'b1;
    wait_cyc(5);
    // R2: plain restart on channel 0, channel 1 untouched (R3)
    ovl[0] = 1'b1; wait_cyc(2);
    chk(ch_en[0], 0, "R2 off"); chk(ch_en[1], 1, "R3 neighbour");
    wait_cyc(30); ovl[0] = 1'b0; wait_cyc(2 * TDIV);
    chk(ch_en[0], 1, "R2 resumed");
    // R4: spike with diagnostics enabled
    diag_en = 1'b1; ovl[1] = 1'b1; wait_cyc(2); ovl[1] = 1'b0;
    chk(ch_en[1], 0, "R4 held during filter"); wait_cyc(2 * TDIV);
    chk(ch_en[1], 1, "R4 resumed"); chk(cycle_done[1], 0, "R4 no cycle");
    // R5/R6: full window on channel 2, supply comparator drops once
    ovl[2] = 1'b1; cmp_gnd[2] = 1'b1; cmp_load[2] = 1'b1; cmp_sup[2] = 1'b1;
    wait_cyc(40 * TDIV); cmp_sup[2] = 1'b0; wait_cyc(1); cmp_sup[2] = 1'b1;
    wait_cyc(70 * TDIV);
    chk(cycle_done[2], 1, "R5 done"); chk(flt_gnd[2], 1, "R6 gnd"); chk(flt_load[2], 1, "R6 load");
    chk(flt_sup[2], 0, "R6 sup dropped"); chk(flt_perm[2], 1, "R8 perm"); chk(ch_en[3], 1, "R3 ch3");
    ovl[2] = 1'b0; cmp_gnd[2] = 0; cmp_sup[2] = 0; cmp_load[2] = 0; wait_cyc(2 * TDIV);
    chk(ch_en[2], 1, "R5 restart resumes");
    // R7: new overload while done gets restart only
    ovl[2] = 1'b1; wait_cyc(150 * TDIV / 10); ovl[2] = 1'b0; wait_cyc(2 * TDIV);
    chk(ch_en[2], 1, "R7 restart only"); chk(flt_gnd[2], 1, "R7 flags kept");
    rearm = 1'b1; wait_cyc(1); rearm = 1'b0; wait_cyc(1);
    chk(cycle_done[2], 0, "R7 rearm"); chk(flt_load[2], 1, "R8 flags survive rearm");
    // R9: abort mid-window on channel 3
    ovl[3] = 1'b1; cmp_gnd[3] = 1'b1; wait_cyc(20 * TDIV);
    diag_en = 1'b0; wait_cyc(2);
    chk(cycle_done[3], 0, "R9 aborted"); chk(flt_gnd[3], 0, "R9 no latch");
    ovl[3] = 1'b0; cmp_gnd[3] = 1'b0; wait_cyc(2 * TDIV);
    chk(ch_en[3], 1, "R9 restart resumes");
    wait_cyc(10);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule